// File: doc/BRIEF.md
# Dual-Mode Host Bus Port for a Dot-Matrix Display Controller

This block is the processor-facing side of a graphic display controller. A host reaches it over an 8-bit bus. A static pin selects one of two strobe conventions. In the first, a single enable is qualified by a read/write level. In the second, there are separate active-low read and write strobes. A pair of chip-select inputs gates all traffic. A data/control select input splits each access into one of four transfers: display data write, display data read, status read and instruction write.

Display memory holds 65 rows by 100 columns. It is split into eight byte-tall pages plus a one-row icon page, and it is accessed one column byte at a time. Every data access goes through a one-byte holding register and moves the column pointer forward by one. Reads are pipelined, so the first read after the address is moved returns whatever the holder already had. Strobes are brought into the system clock domain before they are used. The bus itself is split into an input, an output and an output enable that a pad ring combines.

Top module: `lcd_host_port`

## Requirements
- R1: The port is selected only when `sel_n` is 0 and `sel` is 1. While deselected, `bus_oe` stays 0 and strobes change no page, column, holder or memory content.
- R2: With `mode68` = 0, a write takes effect on the rising edge of `stb_b` (active-low write strobe). `bus_oe` is 1 while `stb_a` (active-low read strobe) is low, and a read completes on its rising edge.
- R3: With `mode68` = 1, `stb_a` is the enable and `stb_b` is the direction (1 = read, 0 = write). `bus_oe` is 1 while both are high, and the access completes on the falling edge of `stb_a`.
- R4: `dc` = 1 selects display data and `dc` = 0 selects control. A control read drives the status byte `{busy, 7'b0000000}`.
- R5: While `busy` is 1, data writes, data reads and instruction writes change no state. Status reads still return bit 7 = 1.
- R6: A data write stores the byte at the current page and column, also loads it into the holder, and then advances the column by one.
- R7: A data read drives the holder contents. It then reloads the holder from memory at the current page and column and advances the column, so the first read after an address change returns the earlier holder value.
- R8: Memory bit 0 of a byte is the top row of its page. Page 8 (the icon row) stores only bit 0 and reads back with bits 7..1 at 0.
- R9: The effective column never exceeds 99. An access at column 99 leaves it at 99, and a column value loaded above 99 acts as 99.
- R10: The instruction `1011pppp` sets the page (values 9..15 are ignored). `0001hhhh` and `0000llll` set the column's high and low nibbles. Other instructions have no effect, and no instruction changes the holder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| dc | input | 1 | 1 = display data, 0 = control |
| mode68 | input | 1 | Strobe convention: 1 = enable + direction, 0 = separate read/write strobes |
| stb_a | input | 1 | Enable (mode68=1) or active-low read strobe (mode68=0) |
| stb_b | input | 1 | Direction (mode68=1) or active-low write strobe (mode68=0) |
| busy | input | 1 | Controller busy indication from the core |
| bus_in | input | 8 | Data arriving from the host bus |
| bus_out | output | 8 | Data driven toward the host bus |
| bus_oe | output | 1 | Output enable for the bus drivers |

## Verification
The assertions assume four things about the inputs. Data, select and direction are held steady from before a strobe edge until several clocks after it. The strobes stay at their idle levels whenever the strobe convention changes. Each strobe phase lasts at least three clocks, so no synchronised edge is missed. The bench drives every access phase for four clocks and holds the data for four or five clocks after the closing edge. It only changes `mode68` while the port is deselected and the strobes are parked at the idle levels of the new convention.

// File: rtl/lcdp_pkg.sv
// Shared parameters and types for the host bus port.
// Assumes one column byte per access and an icon page at the top index.
package lcdp_pkg;
    parameter int COLS   = 100;
    parameter int PAGES  = 9;
    parameter int DW     = 8;
    localparam int COL_W  = $clog2(COLS);
    localparam int PAGE_W = $clog2(PAGES);

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_DWR  = 2'd1,
        EV_DRD  = 2'd2,
        EV_CWR  = 2'd3
    } bus_ev_e;
endpackage

// File: rtl/lcdp_strobe_sync.sv
// Brings N asynchronous strobe lines into the clock domain.
// Two flops per line plus an edge register; reset loads the present
// input level so no false edge appears when reset is released.
module lcdp_strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic s1, s2, s3;
            // Synchronise one line and keep its previous synchronised value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= raw[g];
                    s2 <= raw[g];
                    s3 <= raw[g];
                end else begin
                    s1 <= raw[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl[g] = s2;
            assign chg[g] = s2 ^ s3;
        end
    endgenerate
endmodule

// File: rtl/lcdp_decode.sv
// Turns synchronised strobes, selects and busy into one transfer event.
// Assumes dc, the selects and bus data are stable around each strobe edge.
module lcdp_decode
    import lcdp_pkg::*;
(
    input  logic    mode68,
    input  logic    cs_act,
    input  logic    dc,
    input  logic    busy,
    input  logic [1:0] lvl,
    input  logic [1:0] chg,
    output bus_ev_e ev,
    output logic    rd_level
);
    logic rd_done, wr_done;

    // Map the two strobe conventions onto common read/write completions.
    always_comb begin
        if (mode68) begin
            rd_done  = chg[0] & ~lvl[0] & lvl[1];
            wr_done  = chg[0] & ~lvl[0] & ~lvl[1];
            rd_level = lvl[0] & lvl[1];
        end else begin
            rd_done  = chg[0] & lvl[0];
            wr_done  = chg[1] & lvl[1];
            rd_level = ~lvl[0];
        end
    end

    // Qualify completions with select, data/control and busy.
    always_comb begin
        ev = EV_NONE;
        if (cs_act && !busy) begin
            if (dc && wr_done)       ev = EV_DWR;
            else if (dc && rd_done)  ev = EV_DRD;
            else if (!dc && wr_done) ev = EV_CWR;
        end
    end
endmodule

// File: rtl/lcdp_addr.sv
// Page and column pointers: instruction-driven address sets and
// saturating column advance on every data access.
// Assumes at most one event per cycle.
module lcdp_addr
    import lcdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_e           ev,
    input  logic [DW-1:0]     cmd,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col_eff
);
    localparam int CREG_W = 8;
    localparam logic [CREG_W-1:0] LAST = CREG_W'(COLS - 1);

    logic [CREG_W-1:0] col_q;
    logic              adv;

    assign col_eff = (col_q > LAST) ? LAST[COL_W-1:0] : col_q[COL_W-1:0];
    assign adv     = (ev == EV_DWR) || (ev == EV_DRD);

    // Update pointers from address-set instructions and data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page  <= '0;
            col_q <= '0;
        end else if (ev == EV_CWR) begin
            case (cmd[7:4])
                4'b1011: if (int'(cmd[3:0]) < PAGES) page <= PAGE_W'(cmd[3:0]);
                4'b0001: col_q[7:4] <= cmd[3:0];
                4'b0000: col_q[3:0] <= cmd[3:0];
                default: ;
            endcase
        end else if (adv) begin
            col_q <= (col_eff == LAST[COL_W-1:0]) ? LAST
                                                  : CREG_W'(col_eff) + 1'b1;
        end
    end

    assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (col_eff < LAST[COL_W-1:0]) |=> col_eff == COL_W'($past(col_eff) + 1'b1));

    assert_col_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (col_eff == LAST[COL_W-1:0]) |=> col_eff == LAST[COL_W-1:0]);

    assert_page_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(page) < PAGES);
endmodule

// File: rtl/lcdp_ram.sv
// Display memory: eight byte-wide pages plus a one-bit icon row.
// Asynchronous read, synchronous write; contents are not reset.
module lcdp_ram
    import lcdp_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = (PAGES - 1) * COLS;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0]    mem  [DEPTH];
    logic             icon [COLS];
    logic             icon_sel;
    logic [IDX_W-1:0] idx;

    assign icon_sel = (page == PAGE_W'(PAGES - 1));
    assign idx      = IDX_W'(page[PAGE_W-2:0]) * IDX_W'(COLS) + IDX_W'(col);

    // Store a full byte on a main page or bit 0 on the icon row.
    always_ff @(posedge clk) begin
        if (we) begin
            if (icon_sel) icon[col] <= wdata[0];
            else          mem[idx]  <= wdata;
        end
    end

    // Read the addressed byte; icon row upper bits read as zero.
    always_comb begin
        if (icon_sel) rdata = {{(DW-1){1'b0}}, icon[col]};
        else          rdata = mem[idx];
    end
endmodule

// File: rtl/lcd_host_port.sv
// Host bus port of a dot-matrix display controller. Selects the strobe
// convention by pin, decodes four transfer types, and moves data between
// the bus and display memory through a one-byte holder.
// Assumes bus inputs stay stable for a few clocks around strobe edges.
module lcd_host_port
    import lcdp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          sel,
    input  logic          dc,
    input  logic          mode68,
    input  logic          stb_a,
    input  logic          stb_b,
    input  logic          busy,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);
    logic [1:0]        lvl, chg;
    logic              cs_act, rd_level;
    bus_ev_e           ev;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic [DW-1:0]     ram_rd, holder;

    assign cs_act = !sel_n && sel;

    lcdp_strobe_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({stb_b, stb_a}), .lvl(lvl), .chg(chg)
    );

    lcdp_decode u_dec (
        .mode68(mode68), .cs_act(cs_act), .dc(dc), .busy(busy),
        .lvl(lvl), .chg(chg), .ev(ev), .rd_level(rd_level)
    );

    lcdp_addr u_addr (
        .clk(clk), .rst_n(rst_n), .ev(ev), .cmd(bus_in),
        .page(page), .col_eff(col)
    );

    lcdp_ram u_ram (
        .clk(clk), .we(ev == EV_DWR), .page(page), .col(col),
        .wdata(bus_in), .rdata(ram_rd)
    );

    // Holder takes write data, or memory data when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)              holder <= '0;
        else if (ev == EV_DWR)   holder <= bus_in;
        else if (ev == EV_DRD)   holder <= ram_rd;
    end

    assign bus_out = dc ? holder : {busy, {(DW-1){1'b0}}};
    assign bus_oe  = cs_act && rd_level;

    assert_release_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_n && sel) |-> !bus_oe);

    assert_addrset_keeps_holder_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_CWR) |=> $stable(holder));

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |=> $stable(holder));
endmodule

// File: tb/lcd_host_port_test.sv
`timescale 1ns/1ps
module lcd_host_port_test;
    logic clk = 0, rst_n = 0;
    logic sel_n = 1, sel = 1, dc = 0, mode68 = 0;
    logic stb_a = 1, stb_b = 1, busy = 0;
    logic [7:0] bus_in = 0, bus_out;
    logic bus_oe;

    always #2.5 clk = ~clk;

    lcd_host_port uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .dc(dc),
        .mode68(mode68), .stb_a(stb_a), .stb_b(stb_b), .busy(busy),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    int errs = 0, checks = 0;
    bit done = 0;
    logic [7:0] mem [0:8][0:99];
    int   m_page = 0;
    logic [7:0] m_col = 0, m_hold = 0;
    bit   selected = 0;

    function automatic int eff(input logic [7:0] c);
        return (c > 8'd99) ? 99 : int'(c);
    endfunction

    function automatic logic [7:0] ram_val(input int p, input int c);
        return (p == 8) ? {7'b0, mem[8][c][0]} : mem[p][c];
    endfunction

    function automatic logic [7:0] advance(input logic [7:0] c);
        return (eff(c) == 99) ? 8'd99 : 8'(eff(c) + 1);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic raw_write(input logic d, input logic [7:0] v);
        @(negedge clk);
        dc = d; bus_in = v;
        if (mode68) begin stb_b = 0; stb_a = 1; end
        else stb_b = 0;
        repeat (4) @(negedge clk);
        if (mode68) stb_a = 0; else stb_b = 1;
        repeat (4) @(negedge clk);
        if (mode68) stb_b = 1;
    endtask

    task automatic raw_read(input logic d, output logic [7:0] v, output logic oe);
        @(negedge clk);
        dc = d;
        if (mode68) begin stb_b = 1; stb_a = 1; end
        else stb_a = 0;
        repeat (4) @(negedge clk);
        v = bus_out; oe = bus_oe;
        if (mode68) stb_a = 0; else stb_a = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic op_write(input logic [7:0] v);
        raw_write(1'b1, v);
        if (selected && !busy) begin
            if (m_page == 8) mem[8][eff(m_col)] = {7'b0, v[0]};
            else mem[m_page][eff(m_col)] = v;
            m_hold = v;
            m_col = advance(m_col);
        end
    endtask

    task automatic op_cmd(input logic [7:0] c);
        raw_write(1'b0, c);
        if (selected && !busy) begin
            case (c[7:4])
                4'b1011: if (int'(c[3:0]) < 9) m_page = int'(c[3:0]);
                4'b0001: m_col[7:4] = c[3:0];
                4'b0000: m_col[3:0] = c[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic op_read(input string tag);
        logic [7:0] v; logic oe;
        raw_read(1'b1, v, oe);
        check({tag, " data"}, v, m_hold);
        check({tag, " oe"}, {7'b0, oe}, 8'h01);
        if (!busy) begin
            m_hold = ram_val(m_page, eff(m_col));
            m_col = advance(m_col);
        end
    endtask

    task automatic op_status(input string tag);
        logic [7:0] v; logic oe;
        raw_read(1'b0, v, oe);
        check(tag, v, {busy, 7'b0});
    endtask

    task automatic set_addr(input int p, input logic [7:0] c);
        op_cmd(8'hB0 | 8'(p));
        op_cmd({4'b0001, c[7:4]});
        op_cmd({4'b0000, c[3:0]});
    endtask

    task automatic switch_mode(input logic m);
        @(negedge clk);
        sel_n = 1;
        repeat (2) @(negedge clk);
        mode68 = m;
        if (m) begin stb_a = 0; stb_b = 1; end
        else begin stb_a = 1; stb_b = 1; end
        repeat (6) @(negedge clk);
        sel_n = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic random_phase(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            case (k)
                0: op_cmd(8'hB0 | 8'($urandom_range(0, 15)));
                1: op_cmd({4'b0001, 4'($urandom_range(0, 15))});
                2: op_cmd({4'b0000, 4'($urandom_range(0, 15))});
                3: op_cmd(8'($urandom_range(32, 175)) | 8'h20);
                4, 5: op_write(8'($urandom));
                6: op_status({tag, " R4 status"});
                default: op_read({tag, " R7 R8 random read"});
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v; logic oe;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("reset R1 oe deselected", {7'b0, bus_oe}, 8'h00);
        sel_n = 0; selected = 1;
        repeat (2) @(negedge clk);
        op_status("reset R4 status idle");

        // Fill every page in 8080 mode (R2, R6, R8).
        for (int p = 0; p < 9; p++) begin
            set_addr(p, 8'd0);
            for (int c = 0; c < 100; c++) op_write(8'(p * 37 + c * 11 + 5));
        end
        set_addr(3, 8'd10);
        op_read("R7 dummy read after address set");
        op_read("R7 R2 first real read");
        op_read("R6 R2 second read");

        // Icon page: bit 0 only (R8).
        set_addr(8, 8'd4);
        op_write(8'hFE);
        set_addr(8, 8'd4);
        op_read("R8 icon dummy");
        op_read("R8 icon byte upper bits zero");

        // Column saturation and out-of-range column (R9).
        set_addr(1, 8'd98);
        op_write(8'hA1); op_write(8'hB2); op_write(8'hC3);
        set_addr(1, 8'd98);
        op_read("R9 dummy"); op_read("R9 col 98"); op_read("R9 col 99");
        op_read("R9 col stays 99");
        set_addr(2, 8'h7F);
        op_read("R9 dummy out of range"); op_read("R9 out-of-range acts as 99");

        // Invalid page ignored, unknown instruction no effect (R10).
        set_addr(5, 8'd20);
        op_cmd(8'hBC);
        op_cmd(8'h5A);
        op_read("R10 dummy"); op_read("R10 page 12 ignored");

        // Busy blocks everything but status (R5).
        busy = 1;
        op_status("R5 status busy bit");
        op_write(8'h3C);
        op_cmd(8'hB7);
        op_read("R5 read while busy drives holder");
        busy = 0;
        op_read("R5 state unchanged after busy");
        op_read("R5 follow-on read");

        // Deselected strobes ignored and bus released (R1).
        @(negedge clk); sel_n = 1; selected = 0;
        repeat (2) @(negedge clk);
        op_write(8'h99);
        op_cmd(8'hB1);
        raw_read(1'b1, v, oe);
        check("R1 oe low when deselected", {7'b0, oe}, 8'h00);
        @(negedge clk); sel_n = 0; selected = 1;
        repeat (2) @(negedge clk);
        op_read("R1 no state change while deselected");

        random_phase("mode8080 R2", 300);

        // Enable/direction convention (R3).
        switch_mode(1'b1);
        set_addr(6, 8'd50);
        op_write(8'h5E);
        set_addr(6, 8'd50);
        op_read("R3 dummy"); op_read("R3 write on falling enable");
        op_status("R3 status read");
        random_phase("mode6800 R3", 300);

        switch_mode(1'b0);
        random_phase("mode8080 again R2", 150);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule